// File: doc/BRIEF.md
# Serial Configuration Bitstream Source

This block is the read side of a serial configuration memory that feeds an FPGA one bit per clock. The stored array is small, and each bit of it is computed from a mask parameter. A reset pin and an active-low chip select sit between the array and the pin. The reset pin does two jobs: at its reset level it acts as a reset, and at the other level it acts as an output enable. The pin itself is modelled by a data value and a drive-enable flag. While the block is selected and out of reset, it presents the bit at the current address and steps the address on each rising edge of the data clock.

After the last stored bit has been clocked out, the block stops driving and pulls its cascade output low, so a following memory can take over the line. The address then stays at the end until the next reset. A separate power-on input clears the address in the same way as the reset pin. A parameter sets which level of the reset pin counts as reset.

Top module: `cfg_bitstream_src`

## Requirements
- R1: Stored bit i (0 <= i < NBITS) equals the XOR of all bits of (i AND DATA_MASK). While `sdo_en` is high, `sdo` shows the bit at the current address. While `sdo_en` is low, `sdo` is 0.
- R2: While the reset pin is at its reset level, the address is zero, `sdo_en` is low and `casc_n` is high, whatever `cs_n` is. The clear takes effect at once and does not wait for a clock edge.
- R3: With reset released and `cs_n` high, `sdo_en` is low and the address holds its value across clock edges.
- R4: With reset released, `cs_n` low and data remaining, `sdo_en` is high and the address advances by one on each rising edge of `dclk`.
- R5: After NBITS bits have been clocked out, `casc_n` is low and `sdo_en` is low. The address holds there without wrapping until a reset.
- R6: A low level on `por_n` clears the address and releases the output, in the same way as the reset pin.
- R7: With RST_ACTIVE_LOW = 1 (the default), a low level on `rst_oe` means reset. With RST_ACTIVE_LOW = 0, a high level means reset.
- R8: If reset is asserted before the clock edge that would send the last bit, reset wins. The address clears and `casc_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dclk | input | 1 | Data clock from the FPGA |
| por_n | input | 1 | Power-on clear, active low |
| rst_oe | input | 1 | Reset / output-enable pin, polarity set by RST_ACTIVE_LOW |
| cs_n | input | 1 | Chip select, active low |
| sdo | output | 1 | Serial data value, 0 when not driven |
| sdo_en | output | 1 | High when the data pin is driven, low for high impedance |
| casc_n | output | 1 | Cascade output, goes low once all data has been sent |

## Verification
Reset and the end-of-data transition can meet in the same clock period. The bench clocks out all but one bit, then asserts reset at the falling edge just before the edge that would send the final bit. The scoreboard expects the address to clear and the cascade output to stay high, with no low pulse. A second copy of the block has the opposite reset polarity and gets the inverted pin. It must match the same expected stream cycle for cycle, including this collision.

// File: rtl/cfg_bitstream_src.sv
module cfg_bitstream_src #(
  parameter int          NBITS          = 48,
  parameter logic [15:0] DATA_MASK      = 16'h002D,
  parameter bit          RST_ACTIVE_LOW = 1'b1
) (
  input  logic dclk,
  input  logic por_n,
  input  logic rst_oe,
  input  logic cs_n,
  output logic sdo,
  output logic sdo_en,
  output logic casc_n
);
  localparam int AW = $clog2(NBITS + 1);
  localparam int SLOTS = 2 ** AW;
  localparam logic [AW-1:0] END_ADDR = AW'(NBITS);

  logic [SLOTS-1:0] rom;
  logic [AW-1:0]    addr;
  logic             rst_hit, clr, done, adv;

  for (genvar i = 0; i < SLOTS; i++) begin : g_rom
    localparam logic [31:0] IDX = i;
    if (i < NBITS) begin : g_used
      assign rom[i] = ^(IDX[15:0] & DATA_MASK);
    end else begin : g_pad
      assign rom[i] = 1'b0;
    end
  end

  assign rst_hit = RST_ACTIVE_LOW ? ~rst_oe : rst_oe;
  assign clr     = rst_hit | ~por_n;
  assign done    = (addr == END_ADDR);
  assign adv     = ~cs_n & ~done;

  always_ff @(posedge dclk or posedge clr) begin
    if (clr)      addr <= '0;
    else if (adv) addr <= addr + 1'b1;
  end

  assign sdo_en = ~clr & ~cs_n & ~done;
  assign sdo    = sdo_en & rom[addr];
  assign casc_n = ~done;
endmodule

module cfg_bitstream_src_chk #(
  parameter int NBITS          = 48,
  parameter bit RST_ACTIVE_LOW = 1'b1,
  localparam int AW = $clog2(NBITS + 1)
) (
  input logic          dclk,
  input logic          por_n,
  input logic          rst_oe,
  input logic          cs_n,
  input logic          sdo,
  input logic          sdo_en,
  input logic          casc_n,
  input logic [AW-1:0] addr
);
  logic rst_lvl;
  assign rst_lvl = RST_ACTIVE_LOW ? ~rst_oe : rst_oe;

  // R2
  rst_clears_chk: assert property (@(posedge dclk) disable iff (!por_n)
    rst_lvl |-> (addr == '0 && !sdo_en && casc_n));

  // R3
  deselect_quiet_chk: assert property (@(posedge dclk) disable iff (!por_n)
    (!rst_lvl && cs_n) |-> !sdo_en);

  // R3
  deselect_hold_chk: assert property (@(posedge dclk) disable iff (!por_n)
    (!rst_lvl && cs_n) |=> (rst_lvl || $stable(addr)));

  // R4
  advance_chk: assert property (@(posedge dclk) disable iff (!por_n)
    (!rst_lvl && !cs_n && casc_n) |=> (rst_lvl || addr == $past(addr) + AW'(1)));

  // R5
  end_quiet_chk: assert property (@(posedge dclk) disable iff (!por_n)
    !casc_n |-> (!sdo_en && !sdo));

  // R5
  end_hold_chk: assert property (@(posedge dclk) disable iff (!por_n)
    (!casc_n && !rst_lvl) |=> (rst_lvl || !casc_n));
endmodule

bind cfg_bitstream_src cfg_bitstream_src_chk #(
  .NBITS(NBITS), .RST_ACTIVE_LOW(RST_ACTIVE_LOW)
) u_chk (
  .dclk(dclk), .por_n(por_n), .rst_oe(rst_oe), .cs_n(cs_n),
  .sdo(sdo), .sdo_en(sdo_en), .casc_n(casc_n), .addr(addr)
);

// File: tb/cfg_bitstream_src_test.sv
module cfg_bitstream_src_test;
  localparam int NBITS = 48;
  localparam logic [15:0] MASK = 16'h002D;

  typedef struct {
    bit    en;
    bit    d;
    bit    c;
    string tag;
  } exp_t;

  logic dclk = 1'b0;
  logic por_n = 1'b0, rst_oe = 1'b1, cs_n = 1'b0;
  logic sdo, sdo_en, casc_n;
  logic sdo_h, sdo_en_h, casc_n_h;

  exp_t q[$];
  int   compared = 0, mismatched = 0;
  int   m_addr = 0;
  bit   finished = 1'b0;

  always #4 dclk = ~dclk;

  cfg_bitstream_src #(.NBITS(NBITS), .DATA_MASK(MASK), .RST_ACTIVE_LOW(1'b1)) uut (
    .dclk(dclk), .por_n(por_n), .rst_oe(rst_oe), .cs_n(cs_n),
    .sdo(sdo), .sdo_en(sdo_en), .casc_n(casc_n));

  // R7: opposite polarity copy, driven with the inverted pin
  cfg_bitstream_src #(.NBITS(NBITS), .DATA_MASK(MASK), .RST_ACTIVE_LOW(1'b0)) uut_hi (
    .dclk(dclk), .por_n(por_n), .rst_oe(~rst_oe), .cs_n(cs_n),
    .sdo(sdo_h), .sdo_en(sdo_en_h), .casc_n(casc_n_h));

  function automatic bit exp_bit(int i);
    logic [15:0] v;
    v = 16'(i);
    return ^(v & MASK);
  endfunction

  task automatic step(input bit por, input bit rst, input bit csn, input string tag);
    exp_t e;
    bit ract;
    @(negedge dclk);
    por_n = por; rst_oe = rst; cs_n = csn;
    ract = !rst || !por;
    if (ract) m_addr = 0;
    e.en  = !ract && !csn && (m_addr < NBITS);
    e.d   = e.en ? exp_bit(m_addr) : 1'b0;
    e.c   = (m_addr != NBITS);
    e.tag = tag;
    q.push_back(e);
    @(posedge dclk);
    if (!ract && !csn && m_addr < NBITS) m_addr++;
  endtask

  task automatic cmp(input string tag, input string what, input bit act, input bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  initial begin
    forever begin
      @(negedge dclk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "sdo_en", sdo_en, e.en);
        cmp(e.tag, "sdo", sdo, e.d);
        cmp(e.tag, "casc_n", casc_n, e.c);
        cmp({e.tag, "/R7"}, "sdo_en_hi", sdo_en_h, e.en);
        cmp({e.tag, "/R7"}, "sdo_hi", sdo_h, e.d);
        cmp({e.tag, "/R7"}, "casc_n_hi", casc_n_h, e.c);
      end
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) step(0, 1, 0, "R6_powerup");
    for (int i = 0; i < 2; i++) step(1, 0, 0, "R2_reset_sel");
    for (int i = 0; i < 2; i++) step(1, 0, 1, "R2_reset_desel");
    for (int i = 0; i < 3; i++) step(1, 1, 1, "R3_hold");
    for (int i = 0; i < 10; i++) step(1, 1, 0, "R4_R1_stream");
    for (int i = 0; i < 3; i++) step(1, 1, 1, "R3_pause");
    for (int i = 0; i < NBITS - 10 + 4; i++) step(1, 1, 0, "R5_R1_to_end");
    step(1, 1, 1, "R5_end_desel");
    step(1, 0, 0, "R2_reset_after_end");
    for (int i = 0; i < NBITS - 1; i++) step(1, 1, 0, "R8_R1_prefill");
    step(1, 0, 0, "R8_reset_at_last");
    for (int i = 0; i < 3; i++) step(1, 1, 0, "R8_restart");
    for (int i = 0; i < 5; i++) step(1, 1, 0, "R4_run");
    step(0, 1, 0, "R6_por_pulse");
    for (int i = 0; i < 4; i++) step(1, 1, 0, "R6_R1_after_por");
    @(negedge dclk);
    @(negedge dclk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule